// File: doc/BRIEF.md
# Serial Scan to System Bus Access Engine

This block lets a debugger read and write system memory through a boundary-scan test port. An external TAP controller supplies the decoded instruction selects and one-cycle event pulses for Capture-DR, Shift-DR, Update-DR and Update-IR, all in the `clk` domain. The block then turns the serial scans into transfers on a simple bus master port. That port holds a request until a one-cycle ready returns.

Three single-access instructions are supported. The sized form takes an explicit transfer size. The word form always moves 32 bits. The register form reaches a window of 32-bit debug registers through a 7-bit index. A single access needs an address scan and then a data scan. The block instruction needs one data scan per transfer. Before each block transfer it steps the address by the byte size of the previous transfer.

Every capture reports whether a bus access is still outstanding. Any request made while an access is outstanding is dropped. A cancel instruction removes a bus access that is stuck.

Top module: `jtag_bus_bridge`

## Requirements
- R1: After reset no bus request is raised, and the first capture returns busy = 0 and error = 0.
- R2: Every data-register scan is 41 bits long. The bit shifted in i-th (counting from 0) lands in scan bit i. A capture puts busy in bit 0 and the error flag in bit 1, so both come out first and second. It also puts the last read data, least significant bit first, in bits 33:2.
- R3: For an address scan, bit 2 set means read. Bits 4:3 hold the size code (0 byte, 1 half, 2 word, 3 invalid) and bits 40:5 hold the 36-bit address. For a write, the address scan raises no request. The following data scan, with the write data in bits 40:9, raises one write request carrying that address, size and data.
- R4: A read is requested at the Update-DR of its address scan, and its data is returned in the capture of the following scan.
- R5: The word instruction always issues size code 2, whatever the size field holds.
- R6: The register instruction takes a 7-bit index from bits 11:5 and issues a word access at REG_BASE + 4 × index.
- R7: A misaligned address, or size code 3, issues no request. It sets the error bit in the next capture, and that capture clears the bit.
- R8: The request and its fields are held until ready. Busy reads 1 in any capture made meanwhile, and it clears on ready.
- R9: An Update-DR made while busy is ignored. An address scanned in during a pending write is discarded, and the engine stays in the address phase.
- R10: Each Update-DR under the block instruction advances the address by the last transfer size. It then writes the scanned data, or reads, following the direction of the last access.
- R11: An Update-IR into the block instruction, after a read whose data has already been scanned out, starts the next read at once at the advanced address.
- R12: Update-IR of the cancel instruction drops an outstanding request and clears busy. A ready arriving afterwards leaves the read data unchanged.
- R13: Update-IR of any other instruction while busy leaves the outstanding access running to completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared with the TAP controller |
| rstN | input | 1 | Active-low asynchronous reset |
| selSized | input | 1 | Sized access instruction selected |
| selWord | input | 1 | Word access instruction selected |
| selReg | input | 1 | Debug register access instruction selected |
| selBlock | input | 1 | Block transfer instruction selected |
| selCancel | input | 1 | Cancel instruction selected |
| capDr | input | 1 | Capture-DR event pulse |
| shiftDr | input | 1 | Shift-DR event pulse, one bit per cycle |
| updDr | input | 1 | Update-DR event pulse |
| updIr | input | 1 | Update-IR event pulse |
| tdi | input | 1 | Serial scan input |
| tdo | output | 1 | Serial scan output |
| busReq | output | 1 | Bus request, held until ready |
| busWe | output | 1 | Bus write enable |
| busAddr | output | 36 | Bus byte address |
| busSize | output | 2 | Transfer size code |
| busWdata | output | 32 | Bus write data |
| busReady | input | 1 | One-cycle transfer completion |
| busRdata | input | 32 | Read data, valid with ready |

## Verification
The main function is tried with write-then-data scan pairs, read address scans followed by a capture scan, and the word and register forms. Comparing the address, size, direction and data seen at the bus port separates correct field decoding from swapped or forced fields. Block sequences are run in both directions, started by Update-DR and by Update-IR. They show whether the step follows the last size, and whether the Update-IR start happens only after the read data has been scanned out. A stalled slave keeps the engine busy, so the bench can show that scans are dropped, that the engine stays in the address phase, that a new non-cancel instruction leaves the access running, and that a cancel and a late ready leave the engine idle with its old data.

// File: rtl/jbb_pkg.sv
package jbb_pkg;

  // size codes carried in an address scan
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;
  localparam logic [1:0] SZ_BAD  = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;    // load busy, error and read data into the scan register
    logic shift;      // move the scan register one bit toward tdo
    logic loadAddr;   // take address and size from the scan register
    logic loadWdata;  // take write data from the scan register
    logic advance;    // step the address by the current size
    logic loadRdata;  // take bus read data
  } dpStrobe_t;

endpackage

// File: rtl/jbb_datapath.sv
module jbb_datapath
  import jbb_pkg::*;
#(
  parameter int AW = 36,
  parameter int DW = 32,
  parameter int REG_IDX_W = 7,
  parameter logic [AW-1:0] REG_BASE = '0
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     stb,
  input  logic          tdi,
  input  logic          selWord,
  input  logic          selReg,
  input  logic          busyIn,
  input  logic          errIn,
  input  logic [DW-1:0] busRdata,
  output logic          tdo,
  output logic          fieldRead,
  output logic          fieldBad,
  output logic [AW-1:0] busAddr,
  output logic [1:0]    busSize,
  output logic [DW-1:0] busWdata
);

  localparam int SR_W  = AW + 5;
  localparam int RD_LO = 2;
  localparam int WD_LO = SR_W - DW;

  logic [SR_W-1:0] scanQ;
  logic [AW-1:0]   addrQ;
  logic [1:0]      sizeQ;
  logic [DW-1:0]   wdataQ;
  logic [DW-1:0]   rdataQ;

  logic [AW-1:0]        fAddr;
  logic [1:0]           fSize;
  logic [REG_IDX_W-1:0] regIdx;

  assign tdo = scanQ[0];

  // address scan decode
  assign regIdx    = scanQ[5 +: REG_IDX_W];
  assign fieldRead = scanQ[2];
  always_comb begin
    if (selReg)
      fAddr = REG_BASE + (AW'(regIdx) << 2);
    else
      fAddr = scanQ[SR_W-1:5];
    if (selReg || selWord)
      fSize = SZ_WORD;
    else
      fSize = scanQ[4:3];
  end

  always_comb begin
    unique case (fSize)
      SZ_BYTE: fieldBad = 1'b0;
      SZ_HALF: fieldBad = fAddr[0];
      SZ_WORD: fieldBad = |fAddr[1:0];
      default: fieldBad = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scanQ <= '0;
    end else if (stb.capture) begin
      scanQ <= '0;
      scanQ[0] <= busyIn;
      scanQ[1] <= errIn;
      scanQ[RD_LO +: DW] <= rdataQ;
    end else if (stb.shift) begin
      scanQ <= {tdi, scanQ[SR_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      sizeQ  <= SZ_BYTE;
      wdataQ <= '0;
      rdataQ <= '0;
    end else begin
      if (stb.loadAddr) begin
        addrQ <= fAddr;
        sizeQ <= fSize;
      end else if (stb.advance) begin
        addrQ <= addrQ + (AW'(1) << sizeQ);
      end
      if (stb.loadWdata) wdataQ <= scanQ[WD_LO +: DW];
      if (stb.loadRdata) rdataQ <= busRdata;
    end
  end

  assign busAddr  = addrQ;
  assign busSize  = sizeQ;
  assign busWdata = wdataQ;

  // R9: the transfer address cannot move while an access is outstanding
  a_r9_addr_frozen: assert property (@(posedge clk) disable iff (!rstN)
    busyIn |=> (!busyIn || $stable(busAddr)));

endmodule

// File: rtl/jbb_ctrl.sv
module jbb_ctrl
  import jbb_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      selAcc,
  input  logic      selBlock,
  input  logic      selCancel,
  input  logic      capDr,
  input  logic      shiftDr,
  input  logic      updDr,
  input  logic      updIr,
  input  logic      fieldRead,
  input  logic      fieldBad,
  input  logic      busReady,
  output dpStrobe_t stb,
  output logic      busy,
  output logic      err,
  output logic      busWe
);

  logic busyQ, busyN;
  logic weQ, weN;
  logic inDataQ, inDataN;    // single access waiting for its data scan
  logic errQ, errN;
  logic lastReadQ, lastReadN;
  logic seenQ, seenN;        // data of last read already scanned out
  logic cancelNow;

  assign cancelNow = updIr && selCancel;

  always_comb begin
    stb         = '0;
    stb.capture = capDr;
    stb.shift   = shiftDr;
    busyN       = busyQ;
    weN         = weQ;
    inDataN     = inDataQ;
    errN        = errQ;
    lastReadN   = lastReadQ;
    seenN       = seenQ;

    if (capDr) errN = 1'b0;

    if (busyQ && busReady) begin
      busyN         = 1'b0;
      stb.loadRdata = !weQ && !cancelNow;
    end

    if (updIr) begin
      if (selCancel) begin
        busyN   = 1'b0;
        inDataN = 1'b0;
      end else if (!busyQ && selAcc) begin
        inDataN = 1'b0;
      end else if (!busyQ && selBlock && lastReadQ && seenQ) begin
        stb.advance = 1'b1;
        busyN       = 1'b1;
        weN         = 1'b0;
        seenN       = 1'b0;
      end
    end

    if (updDr && !busyQ) begin
      if (selAcc) begin
        if (!inDataQ) begin
          if (fieldBad) begin
            errN = 1'b1;
          end else begin
            stb.loadAddr = 1'b1;
            lastReadN    = fieldRead;
            inDataN      = 1'b1;
            seenN        = 1'b0;
            if (fieldRead) begin
              busyN = 1'b1;
              weN   = 1'b0;
            end
          end
        end else begin
          inDataN = 1'b0;
          if (lastReadQ) begin
            seenN = 1'b1;
          end else begin
            stb.loadWdata = 1'b1;
            busyN         = 1'b1;
            weN           = 1'b1;
          end
        end
      end else if (selBlock) begin
        stb.advance = 1'b1;
        busyN       = 1'b1;
        if (lastReadQ) begin
          weN = 1'b0;
        end else begin
          stb.loadWdata = 1'b1;
          weN           = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ     <= 1'b0;
      weQ       <= 1'b0;
      inDataQ   <= 1'b0;
      errQ      <= 1'b0;
      lastReadQ <= 1'b0;
      seenQ     <= 1'b0;
    end else begin
      busyQ     <= busyN;
      weQ       <= weN;
      inDataQ   <= inDataN;
      errQ      <= errN;
      lastReadQ <= lastReadN;
      seenQ     <= seenN;
    end
  end

  assign busy  = busyQ;
  assign err   = errQ;
  assign busWe = weQ;

  // R8: an outstanding access stays put until ready or cancel
  a_r8_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !busReady && !cancelNow) |=> (busyQ && $stable(busWe)));

  // R8: ready always ends the access
  a_r8_ready_ends: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && busReady) |=> !busyQ);

  // R12: cancel ends the access in the next cycle
  a_r12_cancel_drops: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && cancelNow) |=> !busyQ);

  // R7: a rejected address neither starts a transfer nor stays silent
  a_r7_bad_no_req: assert property (@(posedge clk) disable iff (!rstN)
    (updDr && selAcc && !busyQ && !inDataQ && fieldBad) |=> (!busyQ && errQ));

  // R13: a non-cancel instruction update leaves the access outstanding
  a_r13_keep_running: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && updIr && !selCancel && !busReady) |=> busyQ);

endmodule

// File: rtl/jtag_bus_bridge.sv
module jtag_bus_bridge
  import jbb_pkg::*;
#(
  parameter int AW = 36,
  parameter int DW = 32,
  parameter int REG_IDX_W = 7,
  parameter logic [AW-1:0] REG_BASE = 36'h8_0000_0000
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          selSized,
  input  logic          selWord,
  input  logic          selReg,
  input  logic          selBlock,
  input  logic          selCancel,
  input  logic          capDr,
  input  logic          shiftDr,
  input  logic          updDr,
  input  logic          updIr,
  input  logic          tdi,
  output logic          tdo,
  output logic          busReq,
  output logic          busWe,
  output logic [AW-1:0] busAddr,
  output logic [1:0]    busSize,
  output logic [DW-1:0] busWdata,
  input  logic          busReady,
  input  logic [DW-1:0] busRdata
);

  dpStrobe_t stb;
  logic busy, err, fieldRead, fieldBad;

  jbb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .selAcc(selSized | selWord | selReg),
    .selBlock(selBlock), .selCancel(selCancel),
    .capDr(capDr), .shiftDr(shiftDr), .updDr(updDr), .updIr(updIr),
    .fieldRead(fieldRead), .fieldBad(fieldBad), .busReady(busReady),
    .stb(stb), .busy(busy), .err(err), .busWe(busWe)
  );

  jbb_datapath #(
    .AW(AW), .DW(DW), .REG_IDX_W(REG_IDX_W), .REG_BASE(REG_BASE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .tdi(tdi),
    .selWord(selWord), .selReg(selReg),
    .busyIn(busy), .errIn(err), .busRdata(busRdata),
    .tdo(tdo), .fieldRead(fieldRead), .fieldBad(fieldBad),
    .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata)
  );

  assign busReq = busy;

endmodule

// File: tb/sim_jtag_bus_bridge.sv
module sim_jtag_bus_bridge;

  localparam int CLK_PERIOD = 10;
  localparam logic [35:0] REGB = 36'h8_0000_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selSized = 0, selWord = 0, selReg = 0, selBlock = 0, selCancel = 0;
  logic capDr = 0, shiftDr = 0, updDr = 0, updIr = 0, tdi = 0;
  logic tdo, busReq, busWe;
  logic [35:0] busAddr;
  logic [1:0]  busSize;
  logic [31:0] busWdata, busRdata, slvRdata;
  logic busReady, slvReady, lateReady;

  int nChk = 0, nFail = 0, reqCount = 0, latCnt = 0;
  bit stall = 0, done = 0;
  logic [35:0] lastAddr;
  logic [1:0]  lastSize;
  logic        lastWe;
  logic [31:0] lastWdata, prevRd;
  logic [40:0] cap;

  always #(CLK_PERIOD/2) clk = ~clk;

  jtag_bus_bridge #(.REG_BASE(REGB)) u0 (
    .clk(clk), .rstN(rstN), .selSized(selSized), .selWord(selWord),
    .selReg(selReg), .selBlock(selBlock), .selCancel(selCancel),
    .capDr(capDr), .shiftDr(shiftDr), .updDr(updDr), .updIr(updIr),
    .tdi(tdi), .tdo(tdo), .busReq(busReq), .busWe(busWe),
    .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata),
    .busReady(busReady), .busRdata(busRdata)
  );

  function automatic logic [31:0] memVal(logic [35:0] a);
    return a[31:0] ^ 32'h5A5A_0F0F;
  endfunction
  function automatic logic [40:0] aVec(logic [35:0] a, logic [1:0] sz, logic rd);
    return {a, sz, rd, 2'b00};
  endfunction
  function automatic logic [40:0] dVec(logic [31:0] d);
    return {d, 9'b0};
  endfunction

  // bus slave: answers three cycles after a request unless stalled
  assign busReady = slvReady | lateReady;
  assign busRdata = lateReady ? 32'hFFFF_FFFF : slvRdata;
  initial begin
    slvReady = 0; lateReady = 0; slvRdata = '0;
  end
  always @(negedge clk) begin
    if (slvReady) begin
      slvReady = 1'b0;
      latCnt   = 0;
    end else if (busReq && !stall) begin
      if (latCnt == 2) begin
        slvReady  = 1'b1;
        slvRdata  = memVal(busAddr);
        reqCount++;
        lastAddr  = busAddr;
        lastSize  = busSize;
        lastWe    = busWe;
        lastWdata = busWdata;
        latCnt    = 0;
      end else begin
        latCnt++;
      end
    end else begin
      latCnt = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setIr(input int code);
    @(negedge clk);
    selSized = (code == 0); selWord = (code == 1); selReg = (code == 2);
    selBlock = (code == 3); selCancel = (code == 4);
    updIr = 1'b1;
    @(negedge clk);
    updIr = 1'b0;
  endtask

  task automatic scan(input logic [40:0] din, output logic [40:0] dout);
    @(negedge clk);
    capDr = 1'b1;
    @(negedge clk);
    capDr = 1'b0;
    for (int i = 0; i < 41; i++) begin
      shiftDr = 1'b1;
      tdi = din[i];
      dout[i] = tdo;
      @(negedge clk);
    end
    shiftDr = 1'b0;
    updDr = 1'b1;
    @(negedge clk);
    updDr = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 40; i++) begin
      if (!busReq) break;
      @(negedge clk);
    end
  endtask

  task automatic tReset();
    chk(busReq == 0, "R1 reset request", busReq, 0);
    setIr(5);
    scan('0, cap);
    chk(cap[0] == 0, "R1 reset busy", cap[0], 0);
    chk(cap[1] == 0, "R1 reset error", cap[1], 0);
  endtask

  task automatic tWrite();
    int c0;
    setIr(0);
    c0 = reqCount;
    scan(aVec(36'h1_0000_0010, 2'd2, 1'b0), cap);
    chk(busReq == 0, "R3 no request after write address", busReq, 0);
    scan(dVec(32'hDEAD_BEEF), cap);
    waitIdle();
    chk(reqCount == c0 + 1, "R3 write count", reqCount, c0 + 1);
    chk(lastAddr == 36'h1_0000_0010, "R3 write address", lastAddr, 36'h1_0000_0010);
    chk(lastWe == 1 && lastSize == 2, "R3 write kind", {lastWe, lastSize}, 3'b110);
    chk(lastWdata == 32'hDEAD_BEEF, "R3 write data", lastWdata, 32'hDEAD_BEEF);
  endtask

  task automatic tRead();
    scan(aVec(36'h3, 2'd0, 1'b1), cap);
    chk(busReq == 1, "R4 read requested at address update", busReq, 1);
    waitIdle();
    chk(lastAddr == 36'h3 && lastWe == 0 && lastSize == 0, "R4 read fields",
        {lastAddr, lastWe, lastSize}, {36'h3, 3'b000});
    scan('0, cap);
    chk(cap[33:2] == memVal(36'h3), "R2 read data in capture", cap[33:2], memVal(36'h3));
    chk(cap[0] == 0, "R2 busy clear in capture", cap[0], 0);
    prevRd = memVal(36'h3);
  endtask

  task automatic tWord();
    setIr(1);
    scan(aVec(36'h20, 2'd0, 1'b1), cap);
    waitIdle();
    chk(lastSize == 2 && lastAddr == 36'h20, "R5 word size forced", {lastAddr, lastSize}, {36'h20, 2'd2});
    scan('0, cap);
    chk(cap[33:2] == memVal(36'h20), "R5 word read data", cap[33:2], memVal(36'h20));
  endtask

  task automatic tReg();
    setIr(2);
    scan(aVec(36'd5, 2'd0, 1'b1), cap);
    waitIdle();
    chk(lastAddr == REGB + 36'd20 && lastSize == 2, "R6 register address",
        lastAddr, REGB + 36'd20);
    scan('0, cap);
    prevRd = memVal(REGB + 36'd20);
    chk(cap[33:2] == prevRd, "R6 register data", cap[33:2], prevRd);
  endtask

  task automatic tMis();
    int c0;
    setIr(0);
    c0 = reqCount;
    scan(aVec(36'h701, 2'd1, 1'b1), cap);
    chk(busReq == 0, "R7 misaligned no request", busReq, 0);
    scan(aVec(36'h700, 2'd2, 1'b0), cap);
    chk(cap[1] == 1, "R7 error reported", cap[1], 1);
    chk(reqCount == c0, "R7 no transfer", reqCount, c0);
    scan(dVec(32'h1), cap);
    chk(cap[1] == 0, "R7 error cleared", cap[1], 0);
    waitIdle();
    chk(lastAddr == 36'h700, "R7 later address accepted", lastAddr, 36'h700);
  endtask

  task automatic tBusy();
    int c0;
    stall = 1;
    scan(aVec(36'h80, 2'd2, 1'b0), cap);
    scan(dVec(32'hCAFE), cap);
    repeat (5) @(negedge clk);
    chk(busReq == 1, "R8 request held while stalled", busReq, 1);
    c0 = reqCount;
    scan(aVec(36'h100, 2'd2, 1'b0), cap);
    chk(cap[0] == 1, "R8 busy in capture", cap[0], 1);
    chk(busAddr == 36'h80, "R9 address ignored while busy", busAddr, 36'h80);
    stall = 0;
    waitIdle();
    chk(reqCount == c0 + 1 && lastWdata == 32'hCAFE, "R8 stalled write completes",
        lastWdata, 32'hCAFE);
    scan(aVec(36'h100, 2'd2, 1'b0), cap);
    scan(dVec(32'hBEEF), cap);
    waitIdle();
    chk(lastAddr == 36'h100 && lastWdata == 32'hBEEF, "R9 stayed in address phase",
        lastAddr, 36'h100);
  endtask

  task automatic tBlockW();
    scan(aVec(36'h600, 2'd1, 1'b0), cap);
    scan(dVec(32'h11), cap);
    waitIdle();
    setIr(3);
    chk(busReq == 0, "R11 no start after write", busReq, 0);
    scan(dVec(32'h22), cap);
    waitIdle();
    chk(lastAddr == 36'h602 && lastWdata == 32'h22 && lastWe == 1, "R10 block write 1",
        lastAddr, 36'h602);
    scan(dVec(32'h33), cap);
    waitIdle();
    chk(lastAddr == 36'h604 && lastWdata == 32'h33, "R10 block write 2", lastAddr, 36'h604);
  endtask

  task automatic tBlockR();
    setIr(0);
    scan(aVec(36'h500, 2'd1, 1'b1), cap);
    waitIdle();
    scan('0, cap);
    chk(cap[33:2] == memVal(36'h500), "R4 half read data", cap[33:2], memVal(36'h500));
    setIr(3);
    chk(busReq == 1, "R11 read started by instruction update", busReq, 1);
    waitIdle();
    chk(lastAddr == 36'h502 && lastWe == 0, "R11 advanced read address", lastAddr, 36'h502);
    scan('0, cap);
    chk(cap[33:2] == memVal(36'h502), "R10 block read data", cap[33:2], memVal(36'h502));
    waitIdle();
    chk(lastAddr == 36'h504, "R10 block read next address", lastAddr, 36'h504);
    prevRd = memVal(36'h504);
  endtask

  task automatic tCancel();
    int c0;
    stall = 1;
    setIr(0);
    scan(aVec(36'h200, 2'd2, 1'b1), cap);
    chk(busReq == 1, "R12 read pending", busReq, 1);
    c0 = reqCount;
    setIr(4);
    chk(busReq == 0, "R12 cancel drops request", busReq, 0);
    @(negedge clk);
    lateReady = 1'b1;
    @(negedge clk);
    lateReady = 1'b0;
    stall = 0;
    scan('0, cap);
    chk(cap[0] == 0, "R12 busy cleared", cap[0], 0);
    chk(cap[33:2] == prevRd, "R12 late ready ignored", cap[33:2], prevRd);
    chk(reqCount == c0, "R12 no transfer", reqCount, c0);
  endtask

  task automatic tContinue();
    int c0;
    stall = 1;
    setIr(0);
    scan(aVec(36'h300, 2'd2, 1'b1), cap);
    c0 = reqCount;
    setIr(1);
    chk(busReq == 1, "R13 access survives new instruction", busReq, 1);
    stall = 0;
    waitIdle();
    chk(reqCount == c0 + 1 && lastAddr == 36'h300, "R13 access completes", lastAddr, 36'h300);
    scan('0, cap);
    chk(cap[33:2] == memVal(36'h300), "R13 data returned", cap[33:2], memVal(36'h300));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tWrite();
    tRead();
    tWord();
    tReg();
    tMis();
    tBusy();
    tBlockW();
    tBlockR();
    tCancel();
    tContinue();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      nChk++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

endmodule